// File: doc/BRIEF.md
# Repeating Status Byte SPI Responder

This block is the slave side of the status-read command of a serial flash memory. It watches the SPI pins (mode 0: data in on the rising SCK edge, data out on the falling edge) while chip select is low. When the first eight bits shifted in form one of the two status opcodes, it drives an eight-bit status byte on the serial output, most significant bit first, starting on the falling SCK edge that ends the opcode.

The byte does not stop after one copy. After bit 0, the next falling edge starts again at bit 7, and this continues for as long as chip select stays low and SCK keeps toggling. On each falling edge that starts a new copy, the block takes a fresh snapshot of the live status inputs: the ready flag, the compare result and a fixed density code. Each copy therefore reports current conditions, and the snapshot does not change while that copy is being shifted out. The SPI pins are brought into the system clock domain through a synchronizer. A rising chip select releases the output enable at once.

Top module: `status_stream_slave`

## Requirements
- R1: After reset, and whenever cs_ni is high, so_oe_o is 0 and so_o is 0.
- R2: Opcode 0x57, shifted in MSB first on the first eight rising SCK edges after cs_ni falls, enables the output. Status bit 7 appears on so_o after the falling edge that follows the eighth rising edge, and the remaining bits follow in descending order, one per falling edge.
- R3: Opcode 0xD7 behaves exactly as 0x57.
- R4: Any other opcode leaves so_oe_o at 0 for the rest of that chip-select period, however many clocks follow.
- R5: The status byte is {ready_i, cmp_mismatch_i, DENSITY_CODE[3:0], 2'b00}. Bit 7 is 1 when ready, and bit 6 is 0 when the compare matched. With the default density code 4'b0111, ready with a match gives 0x9C, and busy with a mismatch gives 0x5C.
- R6: After bit 0, the next falling edge drives bit 7 again, and copies repeat without a limit while cs_ni is low.
- R7: The live status is sampled on the falling edge that launches bit 7 of each copy. A change to ready_i or cmp_mismatch_i during a copy does not alter that copy and shows up in the next one.
- R8: A rising cs_ni drops so_oe_o without waiting for a clock. The next chip-select period needs a fresh status opcode before any output.
- R9: If cs_ni rises partway through the opcode, the partial bits are discarded, and the next period decodes its opcode from its own first eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data into the block |
| ready_i | input | 1 | Live device-ready flag (1 = ready) |
| cmp_mismatch_i | input | 1 | Live compare result (1 = mismatch) |
| so_o | output | 1 | Serial data out, 0 when not enabled |
| so_oe_o | output | 1 | Output enable for the serial data pad |

## Verification
A bit counter that slips in the opcode receiver shows up at the ports as a decode of the wrong eight bits. The output then either never enables or enables one SCK period early or late, and the first sampled byte exposes it. A bit index in the transmitter that loses its place wraps at the wrong point. The second copy then comes out rotated instead of starting again at bit 7, which is visible within sixteen SCK periods of the opcode. A snapshot taken at the wrong moment lets a mid-copy change to ready or compare leak into the current byte, or hold it back from the next byte, so each such byte is compared against values fixed before and after the change.

// File: rtl/status_stream_pkg.sv
package status_stream_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DENS_W = 4;
  localparam logic [BYTE_W-1:0] OPC_STATUS_LO = 8'h57;
  localparam logic [BYTE_W-1:0] OPC_STATUS_HI = 8'hD7;

  function automatic logic is_status_opc(input logic [BYTE_W-1:0] opc);
    return (opc == OPC_STATUS_LO) || (opc == OPC_STATUS_HI);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic ready,
                                                    input logic mismatch,
                                                    input logic [DENS_W-1:0] dens);
    return {ready, mismatch, dens, 2'b00};
  endfunction
endpackage

// File: rtl/ss_pin_sync.sv
module ss_pin_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned CW = STAGES * WIDTH;

  logic [CW-1:0] chain_q;
  logic [CW-1:0] chain_d;

  if (STAGES == 1) begin : g_single
    assign chain_d = d_i;
  end else begin : g_multi
    assign chain_d = {chain_q[CW-WIDTH-1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[CW-1 -: WIDTH];
endmodule

// File: rtl/ss_opcode_rx.sv
module ss_opcode_rx
  import status_stream_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_rise_i,
  input  logic si_i,
  output logic hit_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              hit_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      sh_q   <= '0;
    end else if (cs_n_i) begin
      // deselect discards any partial opcode
      cnt_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (sck_rise_i && !done_q) begin
      sh_q  <= {sh_q[BYTE_W-3:0], si_i};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(BYTE_W - 1)) begin
        done_q <= 1'b1;
        hit_q  <= is_status_opc({sh_q, si_i});
      end
    end
  end

  assign hit_o = hit_q;

  assert_hit_after_full_opcode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_q) |-> ($past(cnt_q) == CNT_W'(BYTE_W - 1)) && $past(sck_rise_i));
endmodule

// File: rtl/ss_status_tx.sv
module ss_status_tx
  import status_stream_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_fall_i,
  input  logic              hit_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_o,
  output logic              oe_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] snap_q;
  logic              so_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      snap_q <= '0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (cs_n_i) begin
      idx_q <= '0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else if (hit_i && sck_fall_i) begin
      oe_q  <= 1'b1;
      idx_q <= idx_q + 1'b1;
      if (idx_q == '0) begin
        // new copy: sample live status, launch MSB
        snap_q <= status_i;
        so_q   <= status_i[BYTE_W-1];
      end else begin
        so_q <= snap_q[~idx_q];
      end
    end
  end

  assign so_o = so_q;
  assign oe_o = oe_q;

  assert_snapshot_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != '0) |=> $stable(snap_q));

  assert_enable_needs_opcode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> hit_i);

  assert_copy_starts_msb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_fall_i && hit_i && !cs_n_i && idx_q == '0) |=> so_q == $past(status_i[BYTE_W-1]));
endmodule

// File: rtl/status_stream_slave.sv
module status_stream_slave
  import status_stream_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DENS_W-1:0] DENSITY_CODE = 4'b0111
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic ready_i,
  input  logic cmp_mismatch_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int unsigned PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010; // sck low, cs high, si low

  logic [PIN_W-1:0]  pins_s;
  logic              sck_s, cs_n_s, si_s;
  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic              hit;
  logic              tx_so, tx_oe;
  logic [BYTE_W-1:0] status_live;

  ss_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, si_i}),
    .q_o   (pins_s)
  );

  assign {sck_s, cs_n_s, si_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  assign status_live = pack_status(ready_i, cmp_mismatch_i, DENSITY_CODE);

  ss_opcode_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n_s),
    .sck_rise_i(sck_rise),
    .si_i      (si_s),
    .hit_o     (hit)
  );

  ss_status_tx u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (cs_n_s),
    .sck_fall_i(sck_fall),
    .hit_i     (hit),
    .status_i  (status_live),
    .so_o      (tx_so),
    .oe_o      (tx_oe)
  );

  // release the pad as soon as the raw select rises
  assign so_oe_o = tx_oe & ~cs_ni;
  assign so_o    = so_oe_o & tx_so;

  assert_deselect_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !tx_oe);

  assert_rx_tx_same_select_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !hit);
endmodule

// File: tb/status_stream_slave_tb.sv
module status_stream_slave_tb;
  localparam int HALF = 8; // clk cycles per SCK half period

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic ready = 1'b1, mism = 1'b0;
  logic so, so_oe;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  status_stream_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .ready_i(ready), .cmp_mismatch_i(mism), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      si = b[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  // chg_bit >= 0: after sampling that bit, drive new live status
  task automatic read_byte(output logic [7:0] b, output logic oe_all,
                           input int chg_bit, input logic nr, input logic nm);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF);
      b[i] = so;
      oe_all &= so_oe;
      if (i == chg_bit) begin
        ready = nr;
        mism  = nm;
      end
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic t_reset();
    wait_clk(3);
    check("R1 oe in reset", {7'd0, so_oe}, 8'h00);
    rst_ni = 1'b1;
    wait_clk(4);
    check("R1 oe idle", {7'd0, so_oe}, 8'h00);
    check("R1 so idle", {7'd0, so}, 8'h00);
  endtask

  task automatic t_opc_57();
    logic [7:0] b; logic oe;
    ready = 1'b1; mism = 1'b0;
    select();
    send_bits(8'h57, 8);
    read_byte(b, oe, -1, 1'b0, 1'b0);
    check("R2 R5 byte 0x57 ready/match", b, 8'h9C);
    check("R2 oe during byte", {7'd0, oe}, 8'h01);
    deselect();
  endtask

  task automatic t_opc_d7();
    logic [7:0] b; logic oe;
    ready = 1'b0; mism = 1'b1;
    select();
    send_bits(8'hD7, 8);
    read_byte(b, oe, -1, 1'b0, 1'b0);
    check("R3 R5 byte 0xD7 busy/mismatch", b, 8'h5C);
    check("R3 oe during byte", {7'd0, oe}, 8'h01);
    deselect();
  endtask

  task automatic t_repeat();
    logic [7:0] b; logic oe;
    ready = 1'b1; mism = 1'b1;
    select();
    send_bits(8'h57, 8);
    for (int k = 0; k < 3; k++) begin
      read_byte(b, oe, -1, 1'b0, 1'b0);
      check("R6 repeated copy", b, 8'hDC);
      check("R6 oe held", {7'd0, oe}, 8'h01);
    end
    deselect();
  endtask

  task automatic t_fresh();
    logic [7:0] b; logic oe;
    ready = 1'b1; mism = 1'b0;
    select();
    send_bits(8'hD7, 8);
    read_byte(b, oe, 4, 1'b0, 1'b1);
    check("R7 copy stable during change", b, 8'h9C);
    read_byte(b, oe, 2, 1'b1, 1'b0);
    check("R7 next copy fresh", b, 8'h5C);
    read_byte(b, oe, -1, 1'b0, 1'b0);
    check("R7 third copy fresh", b, 8'h9C);
    deselect();
  endtask

  task automatic t_bad_opc();
    logic [7:0] b; logic oe;
    logic [7:0] opcs [4] = '{8'h56, 8'h77, 8'hD6, 8'h00};
    ready = 1'b1; mism = 1'b0;
    foreach (opcs[j]) begin
      select();
      send_bits(opcs[j], 8);
      read_byte(b, oe, -1, 1'b0, 1'b0);
      check("R4 no output, oe byte 1", {7'd0, oe}, 8'h00);
      read_byte(b, oe, -1, 1'b0, 1'b0);
      check("R4 no output, oe byte 2", {7'd0, oe}, 8'h00);
      deselect();
    end
  endtask

  task automatic t_cs_end();
    logic [7:0] b; logic oe;
    ready = 1'b1; mism = 1'b0;
    select();
    send_bits(8'h57, 8);
    wait_clk(HALF);
    check("R8 oe before deselect", {7'd0, so_oe}, 8'h01);
    cs_n = 1'b1;
    #1;
    check("R8 oe drops at once", {7'd0, so_oe}, 8'h00);
    check("R1 so low when deselected", {7'd0, so}, 8'h00);
    wait_clk(4 * HALF);
    select();
    si = 1'b0;
    read_byte(b, oe, -1, 1'b0, 1'b0); // shifts opcode 0x00
    read_byte(b, oe, -1, 1'b0, 1'b0);
    check("R8 no output without new opcode", {7'd0, oe}, 8'h00);
    deselect();
  endtask

  task automatic t_abort();
    logic [7:0] b; logic oe;
    ready = 1'b0; mism = 1'b0;
    select();
    send_bits(8'hD7, 4);
    deselect();
    select();
    send_bits(8'h57, 8);
    read_byte(b, oe, -1, 1'b0, 1'b0);
    check("R9 opcode after abort", b, 8'h1C);
    check("R9 oe after abort", {7'd0, oe}, 8'h01);
    deselect();
  endtask

  initial begin
    t_reset();
    t_opc_57();
    t_opc_d7();
    t_repeat();
    t_fresh();
    t_bad_opc();
    t_cs_end();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule